// File: doc/BRIEF.md
# Time-Division Audio Link Frame Receiver

This block is the controller-side receiver for the serial stream a codec sends on a time-division-multiplexed audio link. It runs on the link bit clock and counts out the 256-bit frame itself. It drives the frame sync: high for the 16-bit tag slot, then low for twelve 20-bit data slots. Each incoming serial bit is captured on the falling edge of the bit clock. The captured bits are assembled most-significant bit first into slot words.

The tag slot says which data slots carry valid content in the current frame. The receiver decodes those flags and then picks out four results. The first is the status read-back: the echoed register address from the address slot and the 16-bit read data from the data slot. The second is the codec's slot-request flags. The third is the left and right 20-bit record samples. The fourth is the general-purpose status word. Each result has its own one-cycle strobe, and that strobe fires only when the matching tag flag is set in the same frame. When a slot is flagged invalid, the held output for that slot keeps its value.

Top module: `tdm_frame_rx`

## Requirements
- R1: While reset is asserted and right after it is released, `sync_out` is 1, every strobe is 0 and every data output is zero.
- R2: `sync_out` is high for the first 16 bit clocks of every frame and low for the other 240, so the frame repeats every 256 bit clocks.
- R3: Each serial bit is taken from the value `sdata_in` holds at the falling edge of `clk`. The value at the rising edge has no effect.
- R4: The first 16 bits of a frame form `tag_word`, first bit at bit 15. `tag_stb` pulses in the cycle after the 16th bit of every frame.
- R5: Data slot n (1 to 12) covers frame bits 16+20(n-1) to 16+20n-1, sent most significant bit first. Its validity flag is `tag_word` bit 15-n.
- R6: At the end of slot 1, when tag bit 14 is set, `req_flags` takes slot 1 bits 11..2 and `req_stb` pulses.
- R7: At the end of slot 2, `stat_stb` pulses only when tag bits 14 and 13 are both set. `stat_addr` then takes slot 1 bits 18..12 and `stat_data` takes slot 2 bits 19..4.
- R8: `rec_left` takes slot 3 when tag bit 12 is set, and `left_stb` pulses. `rec_right` takes slot 4 when tag bit 11 is set, and `right_stb` pulses.
- R9: `gpio_word` takes slot 12 when tag bit 3 is set, and `gpio_stb` pulses.
- R10: A slot whose tag bit is clear gives no strobe and leaves its outputs unchanged, whatever data it carries.
- R11: Each strobe is high for exactly one cycle. That cycle is the one right after the last bit of its slot: frame bit 16 for the tag, 36 for requests, 56 for status, 76 for left, 96 for right, and bit 0 of the next frame for the general-purpose word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata_in | input | 1 | Serial data from the codec |
| sync_out | output | 1 | Frame sync, high during the tag slot |
| tag_word | output | 16 | Tag flags of the latest frame |
| tag_stb | output | 1 | Tag slot complete |
| req_flags | output | 10 | Codec slot-request flags |
| req_stb | output | 1 | Request flags updated |
| stat_addr | output | 7 | Echoed register address |
| stat_data | output | 16 | Register read data |
| stat_stb | output | 1 | Status read-back updated |
| rec_left | output | 20 | Left record sample |
| left_stb | output | 1 | Left sample updated |
| rec_right | output | 20 | Right record sample |
| right_stb | output | 1 | Right sample updated |
| gpio_word | output | 20 | General-purpose status slot |
| gpio_stb | output | 1 | General-purpose word updated |

## Verification
The bench builds the block with its default parameters: a 16-bit tag slot, twelve 20-bit data slots, falling-edge capture and the standard field positions. With these values the full 256-cycle frame is in play. That includes the last slot's strobe, which lands in the first cycle of the next frame, and every tag flag with its own slot. The serial line is driven so that it holds the intended bit only around the falling edge and its inverse around the rising edge, so an edge mix-up corrupts every word. The rising-edge build variant is not used by the bench.

// File: rtl/tdm_rx_pkg.sv
`timescale 1ns/1ps
package tdm_rx_pkg;

   // position of the validity flag for data slot n inside the tag word
   function automatic int flag_pos(input int tag_w, input int slot);
      return tag_w - 1 - slot;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tdm_bit_sampler.sv
`timescale 1ns/1ps
module tdm_bit_sampler #(
   parameter bit FALL_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic bit_o
);

   generate
      if (FALL_EDGE) begin : g_fall
         logic cap_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) cap_q <= 1'b0;
            else        cap_q <= din;
         end
         assign bit_o = cap_q;
      end else begin : g_rise
         assign bit_o = din;
      end
   endgenerate

endmodule

// File: rtl/tdm_slot_timer.sv
`timescale 1ns/1ps
module tdm_slot_timer #(
   parameter  int TAG_W     = 16,
   parameter  int SLOT_W    = 20,
   parameter  int NUM_SLOTS = 12,
   localparam int IDX_W     = $clog2(NUM_SLOTS + 1),
   localparam int CNT_W     = $clog2(tdm_rx_pkg::max_of(TAG_W, SLOT_W))
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [IDX_W-1:0] slot_idx,
   output logic             slot_last,
   output logic             sync_o
);

   logic [CNT_W-1:0] bit_cnt;
   logic [CNT_W-1:0] len_m1;

   always_comb begin
      len_m1    = (slot_idx == '0) ? CNT_W'(TAG_W - 1) : CNT_W'(SLOT_W - 1);
      slot_last = (bit_cnt == len_m1);
      sync_o    = (slot_idx == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         slot_idx <= '0;
      end else if (slot_last) begin
         bit_cnt  <= '0;
         slot_idx <= (slot_idx == IDX_W'(NUM_SLOTS)) ? '0 : slot_idx + IDX_W'(1);
      end else begin
         bit_cnt  <= bit_cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/tdm_slot_shifter.sv
`timescale 1ns/1ps
module tdm_slot_shifter #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bit_i,
   output logic [W-1:0] word_o
);

   logic [W-2:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[W-3:0], bit_i};
   end

   // word as it stands once the current bit is appended
   assign word_o = {sh_q, bit_i};

endmodule

// File: rtl/tdm_frame_rx.sv
`timescale 1ns/1ps
module tdm_frame_rx #(
   parameter  int TAG_W      = 16,
   parameter  int SLOT_W     = 20,
   parameter  int NUM_SLOTS  = 12,
   parameter  int ADDR_SLOT  = 1,
   parameter  int DATA_SLOT  = 2,
   parameter  int LEFT_SLOT  = 3,
   parameter  int RIGHT_SLOT = 4,
   parameter  int GPIO_SLOT  = 12,
   parameter  int ADDR_LSB   = 12,
   parameter  int ADDR_W     = 7,
   parameter  int REQ_LSB    = 2,
   parameter  int REQ_W      = 10,
   parameter  int RDATA_LSB  = 4,
   parameter  int RDATA_W    = 16,
   parameter  bit FALL_EDGE  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sdata_in,
   output logic               sync_out,
   output logic [TAG_W-1:0]   tag_word,
   output logic               tag_stb,
   output logic [REQ_W-1:0]   req_flags,
   output logic               req_stb,
   output logic [ADDR_W-1:0]  stat_addr,
   output logic [RDATA_W-1:0] stat_data,
   output logic               stat_stb,
   output logic [SLOT_W-1:0]  rec_left,
   output logic               left_stb,
   output logic [SLOT_W-1:0]  rec_right,
   output logic               right_stb,
   output logic [SLOT_W-1:0]  gpio_word,
   output logic               gpio_stb
);
   import tdm_rx_pkg::*;

   localparam int IDX_W   = $clog2(NUM_SLOTS + 1);
   localparam int F_ADDR  = flag_pos(TAG_W, ADDR_SLOT);
   localparam int F_DATA  = flag_pos(TAG_W, DATA_SLOT);
   localparam int F_LEFT  = flag_pos(TAG_W, LEFT_SLOT);
   localparam int F_RIGHT = flag_pos(TAG_W, RIGHT_SLOT);
   localparam int F_GPIO  = flag_pos(TAG_W, GPIO_SLOT);

   generate
      if (TAG_W < NUM_SLOTS + 1 || TAG_W > SLOT_W)
         $error("tag slot must hold one flag per data slot and fit in a slot word");
      if (SLOT_W < 3)
         $error("slot width too small");
      if (ADDR_LSB + ADDR_W > SLOT_W || REQ_LSB + REQ_W > SLOT_W || RDATA_LSB + RDATA_W > SLOT_W)
         $error("field lies outside the slot word");
      if (ADDR_SLOT < 1 || DATA_SLOT <= ADDR_SLOT || LEFT_SLOT < 1 || RIGHT_SLOT < 1 ||
          GPIO_SLOT < 1 || DATA_SLOT > NUM_SLOTS || LEFT_SLOT > NUM_SLOTS ||
          RIGHT_SLOT > NUM_SLOTS || GPIO_SLOT > NUM_SLOTS)
         $error("slot assignment out of range");
   endgenerate

   logic              rx_bit;
   logic [IDX_W-1:0]  slot_idx;
   logic              slot_last;
   logic [SLOT_W-1:0] word;
   logic [ADDR_W-1:0] addr_hold;

   tdm_bit_sampler #(.FALL_EDGE(FALL_EDGE)) u_samp (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (sdata_in),
      .bit_o (rx_bit)
   );

   tdm_slot_timer #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_idx  (slot_idx),
      .slot_last (slot_last),
      .sync_o    (sync_out)
   );

   tdm_slot_shifter #(.W(SLOT_W)) u_shf (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_i  (rx_bit),
      .word_o (word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_word  <= '0;
         tag_stb   <= 1'b0;
         addr_hold <= '0;
         req_flags <= '0;
         req_stb   <= 1'b0;
         stat_addr <= '0;
         stat_data <= '0;
         stat_stb  <= 1'b0;
         rec_left  <= '0;
         left_stb  <= 1'b0;
         rec_right <= '0;
         right_stb <= 1'b0;
         gpio_word <= '0;
         gpio_stb  <= 1'b0;
      end else begin
         tag_stb   <= 1'b0;
         req_stb   <= 1'b0;
         stat_stb  <= 1'b0;
         left_stb  <= 1'b0;
         right_stb <= 1'b0;
         gpio_stb  <= 1'b0;
         if (slot_last) begin
            if (slot_idx == '0) begin
               tag_word <= word[TAG_W-1:0];
               tag_stb  <= 1'b1;
            end
            if (slot_idx == IDX_W'(ADDR_SLOT)) begin
               addr_hold <= word[ADDR_LSB +: ADDR_W];
               if (tag_word[F_ADDR]) begin
                  req_flags <= word[REQ_LSB +: REQ_W];
                  req_stb   <= 1'b1;
               end
            end
            if (slot_idx == IDX_W'(DATA_SLOT) && tag_word[F_ADDR] && tag_word[F_DATA]) begin
               stat_addr <= addr_hold;
               stat_data <= word[RDATA_LSB +: RDATA_W];
               stat_stb  <= 1'b1;
            end
            if (slot_idx == IDX_W'(LEFT_SLOT) && tag_word[F_LEFT]) begin
               rec_left <= word;
               left_stb <= 1'b1;
            end
            if (slot_idx == IDX_W'(RIGHT_SLOT) && tag_word[F_RIGHT]) begin
               rec_right <= word;
               right_stb <= 1'b1;
            end
            if (slot_idx == IDX_W'(GPIO_SLOT) && tag_word[F_GPIO]) begin
               gpio_word <= word;
               gpio_stb  <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/tdm_frame_rx_chk.sv
`timescale 1ns/1ps
module tdm_frame_rx_chk #(
   parameter int TAG_W     = 16,
   parameter int SLOT_W    = 20,
   parameter int NUM_SLOTS = 12,
   parameter int RDATA_W   = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sync_out,
   input logic               tag_stb,
   input logic               req_stb,
   input logic               stat_stb,
   input logic               left_stb,
   input logic               right_stb,
   input logic               gpio_stb,
   input logic [SLOT_W-1:0]  rec_left,
   input logic [SLOT_W-1:0]  rec_right,
   input logic [SLOT_W-1:0]  gpio_word,
   input logic [RDATA_W-1:0] stat_data
);

   localparam int FRAME_LEN = TAG_W + NUM_SLOTS * SLOT_W;
   localparam int FR_W      = $clog2(FRAME_LEN) + 2;
   localparam int HI_W      = $clog2(TAG_W) + 2;
   localparam int SR_W      = $clog2(SLOT_W) + 2;

   logic [HI_W-1:0] hi_run;
   logic [FR_W-1:0] fr_cnt;
   logic [SR_W-1:0] since_req;
   logic            sync_d;
   logic            sync_rise;

   assign sync_rise = sync_out && !sync_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run    <= '0;
         fr_cnt    <= '0;
         since_req <= '1;
         sync_d    <= 1'b1;
      end else begin
         sync_d    <= sync_out;
         hi_run    <= sync_out ? hi_run + HI_W'(1) : '0;
         fr_cnt    <= sync_rise ? FR_W'(1) : fr_cnt + FR_W'(1);
         if (req_stb)               since_req <= SR_W'(1);
         else if (since_req != '1) since_req <= since_req + SR_W'(1);
      end
   end

   a_r2_sync_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_out) |-> hi_run == HI_W'(TAG_W));

   a_r2_frame_period: assert property (@(posedge clk) disable iff (!rst_n)
      sync_rise |-> fr_cnt == FR_W'(FRAME_LEN));

   a_r4_tag_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_out) |-> tag_stb);

   a_r4_tag_only_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
      tag_stb |-> $fell(sync_out));

   a_r7_stat_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      stat_stb |-> since_req == SR_W'(SLOT_W));

   a_r11_left_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      left_stb |=> !left_stb);

   a_r11_right_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      right_stb |=> !right_stb);

   a_r11_gpio_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      gpio_stb |=> !gpio_stb);

   a_r10_left_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rec_left) |-> left_stb);

   a_r10_right_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rec_right) |-> right_stb);

   a_r10_gpio_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gpio_word) |-> gpio_stb);

   a_r10_stat_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stat_data) |-> stat_stb);

endmodule

bind tdm_frame_rx tdm_frame_rx_chk #(
   .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .RDATA_W(RDATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sync_out  (sync_out),
   .tag_stb   (tag_stb),
   .req_stb   (req_stb),
   .stat_stb  (stat_stb),
   .left_stb  (left_stb),
   .right_stb (right_stb),
   .gpio_stb  (gpio_stb),
   .rec_left  (rec_left),
   .rec_right (rec_right),
   .gpio_word (gpio_word),
   .stat_data (stat_data)
);

// File: tb/tb_tdm_frame_rx.sv
`timescale 1ns/1ps
module tb_tdm_frame_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sdin = 1'b0;
   logic        sync_out;
   logic [15:0] tag_word;
   logic        tag_stb;
   logic [9:0]  req_flags;
   logic        req_stb;
   logic [6:0]  stat_addr;
   logic [15:0] stat_data;
   logic        stat_stb;
   logic [19:0] rec_left;
   logic        left_stb;
   logic [19:0] rec_right;
   logic        right_stb;
   logic [19:0] gpio_word;
   logic        gpio_stb;

   always #4 clk = ~clk;

   tdm_frame_rx dut (
      .clk(clk), .rst_n(rst_n), .sdata_in(sdin), .sync_out(sync_out),
      .tag_word(tag_word), .tag_stb(tag_stb),
      .req_flags(req_flags), .req_stb(req_stb),
      .stat_addr(stat_addr), .stat_data(stat_data), .stat_stb(stat_stb),
      .rec_left(rec_left), .left_stb(left_stb),
      .rec_right(rec_right), .right_stb(right_stb),
      .gpio_word(gpio_word), .gpio_stb(gpio_stb)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [19:0] slot_v [1:12];
   int bitno = 0;
   bit mon_on = 1'b0;

   // monitor counters
   int sync_err, tag_n, req_n, stat_n, left_n, right_n, gpio_n;
   int tag_at, req_at, stat_at, left_at, right_at, gpio_at;
   logic [15:0] tag_first;

   // expected held outputs
   logic [9:0]  e_req;
   logic [6:0]  e_addr;
   logic [15:0] e_data;
   logic [19:0] e_left, e_right, e_gpio;

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (mon_on) begin
         if (sync_out !== ((bitno % 256) < 16)) sync_err++;
         if (tag_stb)   begin if (tag_n == 0) begin tag_at = bitno; tag_first = tag_word; end tag_n++; end
         if (req_stb)   begin if (req_n == 0) req_at = bitno; req_n++; end
         if (stat_stb)  begin if (stat_n == 0) stat_at = bitno; stat_n++; end
         if (left_stb)  begin if (left_n == 0) left_at = bitno; left_n++; end
         if (right_stb) begin if (right_n == 0) right_at = bitno; right_n++; end
         if (gpio_stb)  begin if (gpio_n == 0) gpio_at = bitno; gpio_n++; end
      end
   end

   function automatic logic frame_bit(input logic [15:0] tg, input bit blank, input int k);
      int n, p;
      if (k < 16) return tg[15-k];
      if (blank) return 1'b0;
      n = (k - 16) / 20 + 1;
      p = (k - 16) % 20;
      return slot_v[n][19-p];
   endfunction

   // bit held only around the falling edge; its inverse sits at the rising edge (R3)
   task automatic run_frame(input logic [15:0] tg, input bit blank, input int base);
      for (int k = 0; k < 256; k++) begin
         logic b;
         b = frame_bit(tg, blank, k);
         bitno = base + k;
         sdin = b;
         @(negedge clk);
         #1 sdin = ~b;
         @(posedge clk);
         #1;
      end
   endtask

   task automatic run_scenario(input logic [15:0] tg);
      sync_err = 0; tag_n = 0; req_n = 0; stat_n = 0; left_n = 0; right_n = 0; gpio_n = 0;
      mon_on = 1'b1;
      run_frame(tg, 1'b0, 0);
      run_frame(16'h0000, 1'b1, 256);
      if (tg[14]) e_req = slot_v[1][11:2];
      if (tg[14] && tg[13]) begin e_addr = slot_v[1][18:12]; e_data = slot_v[2][19:4]; end
      if (tg[12]) e_left = slot_v[3];
      if (tg[11]) e_right = slot_v[4];
      if (tg[3])  e_gpio = slot_v[12];
      check("R2", "sync mismatches", sync_err, 0);
      check("R4", "tag strobes", tag_n, 2);
      check("R4", "tag word", tag_first, tg);
      check("R11", "tag strobe cycle", tag_at, 16);
      check("R6", "req strobes", req_n, tg[14]);
      check("R7", "status strobes", stat_n, tg[14] & tg[13]);
      check("R8", "left strobes", left_n, tg[12]);
      check("R8", "right strobes", right_n, tg[11]);
      check("R9", "gpio strobes", gpio_n, tg[3]);
      if (tg[14]) check("R11", "req strobe cycle", req_at, 36);
      if (tg[14] && tg[13]) check("R11", "status strobe cycle", stat_at, 56);
      if (tg[12]) check("R11", "left strobe cycle", left_at, 76);
      if (tg[11]) check("R11", "right strobe cycle", right_at, 96);
      if (tg[3])  check("R11", "gpio strobe cycle", gpio_at, 256);
      check("R6 R10", "req flags", req_flags, e_req);
      check("R7 R10", "status addr", stat_addr, e_addr);
      check("R7 R10", "status data", stat_data, e_data);
      check("R5 R8 R10", "left sample", rec_left, e_left);
      check("R5 R8 R10", "right sample", rec_right, e_right);
      check("R5 R9 R10", "gpio word", gpio_word, e_gpio);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      e_req = '0; e_addr = '0; e_data = '0; e_left = '0; e_right = '0; e_gpio = '0;
      check("R1", "sync", sync_out, 1);
      check("R1", "strobes", {tag_stb, req_stb, stat_stb, left_stb, right_stb, gpio_stb}, 0);
      check("R1", "data", {req_flags, stat_addr, stat_data, rec_left} | {rec_right, gpio_word, tag_word}, 0);
   endtask

   task automatic t_full_pattern();
      for (int n = 1; n <= 12; n++) slot_v[n] = 20'((n * 32'h1F3D7) ^ 32'hA5C3E);
      run_scenario(16'hFFF8);
      check("R3", "left sample from falling-edge bits", rec_left, slot_v[3]);
   endtask

   task automatic t_full_alternating();
      for (int n = 1; n <= 12; n++) slot_v[n] = (n % 2 == 1) ? 20'hAAAAA : 20'h55555;
      slot_v[1] = 20'hFFFFF;
      slot_v[12] = 20'h80001;
      run_scenario(16'hFFF8);
   endtask

   task automatic t_untagged();
      for (int n = 1; n <= 12; n++) slot_v[n] = 20'((n * 32'h0B6E1) ^ 32'h3C3C3);
      run_scenario(16'h8000);
   endtask

   task automatic t_req_only();
      for (int n = 1; n <= 12; n++) slot_v[n] = 20'(n * 32'h11111);
      slot_v[1] = 20'h5A3F4;
      run_scenario(16'hC000);
   endtask

   task automatic t_data_only();
      for (int n = 1; n <= 12; n++) slot_v[n] = 20'hC0FFE ^ 20'(n);
      run_scenario(16'hA000);
   endtask

   task automatic t_left_only();
      for (int n = 1; n <= 12; n++) slot_v[n] = 20'h13579 + 20'(n);
      run_scenario(16'h9000);
   endtask

   task automatic t_right_and_gpio();
      for (int n = 1; n <= 12; n++) slot_v[n] = 20'hFEDCB - 20'(n * 7);
      run_scenario(16'h8808);
   endtask

   initial begin
      t_reset();
      t_full_pattern();
      t_full_alternating();
      t_untagged();
      t_req_only();
      t_data_only();
      t_left_only();
      t_right_and_gpio();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(100000 * 8);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog run did not complete");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule